// File: doc/BRIEF.md
# Programmable Wait-State External Bus Master

This block runs read and write cycles on a parallel external memory bus on behalf of an internal requester. Every cycle is divided into three timed phases: a setup phase before the strobe (lead), the strobe phase (active) and a hold phase after the strobe (trail). Each phase lasts a programmable number of timing clock cycles. Reads and writes have separate settings. An optional doubling switch multiplies every phase length by two.

The internal side presents an address, a direction, write data and a zone number while the block is idle. The block selects one active-low chip select out of the zone vector and drives the address, strobes, direction line and write data. It returns the read data and a one-cycle completion pulse. The bus clock output can follow the timing clock or run at half its rate. In half-rate mode every access begins on a rising edge of the bus clock. To achieve this, the block inserts an idle alignment cycle when a request arrives in the wrong phase. When ready sampling is enabled, a low ready input stretches the active phase one timing cycle at a time.

Top module: `ext_bus_master`

## Requirements
- R1: While reset is held, all chip selects are high, both strobes are high, the direction line is high (read), the write-data enable is low, the completion pulse is low and the address output is zero.
- R2: For a read, the selected chip select stays low for lead+active+trail cycles and the read strobe is low for the active cycles only. A programmed phase count of zero behaves as one.
- R3: For a write, the write phase counts apply in the same way with the write strobe. The write data and its enable are driven for every cycle in which the chip select is low.
- R4: When doubling is set, each effective phase length is twice its programmed value.
- R5: With half-rate off, the bus clock output equals the timing clock. With half-rate on, it toggles once per timing cycle.
- R6: In half-rate mode the first lead cycle is a bus-clock-high cycle. If a request is taken while the bus clock is high, exactly one alignment cycle precedes the lead phase; otherwise there is none. During the alignment cycle all chip selects and strobes are inactive.
- R7: The address output changes only as the lead phase begins. While no chip select is low, including during alignment, it holds the last address driven.
- R8: With ready sampling on, ready is sampled at the end of the last programmed active cycle. Each low sample adds one active cycle, and the active phase ends after the first high sample.
- R9: With ready sampling off, the active phase is exactly its programmed length whatever the ready input does.
- R10: Read data is taken from the data input during the final active cycle, including any ready extension, and is held on the read-data output during the trail phase.
- R11: The completion pulse is high for exactly one cycle, the last trail cycle. The direction line is low during writes and high during reads. A further request is taken only once the block is idle after that pulse.
- R12: Only the chip select numbered by the request's zone goes low, and never more than one at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock |
| rstN | input | 1 | Active-low asynchronous reset |
| useReady | input | 1 | Enable ready sampling in the active phase |
| doubleTiming | input | 1 | Double every phase length |
| halfClk | input | 1 | Bus clock at half the timing clock rate |
| rdLead | input | CNT_W | Read lead cycles |
| rdActive | input | CNT_W | Read active cycles |
| rdTrail | input | CNT_W | Read trail cycles |
| wrLead | input | CNT_W | Write lead cycles |
| wrActive | input | CNT_W | Write active cycles |
| wrTrail | input | CNT_W | Write trail cycles |
| reqValid | input | 1 | Request present |
| reqWrite | input | 1 | Request direction, 1 = write |
| reqAddr | input | ADDR_W | Request address |
| reqWdata | input | DATA_W | Request write data |
| reqZone | input | clog2(ZONES) | Request zone number |
| reqReady | output | 1 | Block idle, a request will be taken |
| rdData | output | DATA_W | Captured read data |
| done | output | 1 | Access completion pulse |
| busClk | output | 1 | Bus clock output |
| csN | output | ZONES | Active-low zone chip selects |
| addrOut | output | ADDR_W | Bus address |
| rdN | output | 1 | Active-low read strobe |
| wrN | output | 1 | Active-low write strobe |
| rnw | output | 1 | Direction line, 1 = read |
| dataOut | output | DATA_W | Write data to the bus |
| dataOe | output | 1 | Write data enable |
| dataIn | input | DATA_W | Read data from the bus |
| readyIn | input | 1 | Synchronous ready |

## Verification
Reads run with the 1/3/1 timing, ready sampling on and doubling off. Ready is held low for zero, two and five samples, and each case must give a distinct active length and a distinct captured word. This is possible because the data input changes value on every active cycle. Writes use 2/4/3 timing on a different zone, which separates the read and write count sets. Further runs with doubling on, all-zero counts, ready sampling off and a ready input held low separate the length arithmetic from the ready path. Half-rate runs start requests after idle gaps of varying length, so both bus-clock phases are met at request time. They show whether an alignment cycle is inserted only when it is needed. A held request checks that no second access starts before the first one completes.

// File: rtl/ebm_pkg.sv
package ebm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ALIGN,
    ST_LEAD,
    ST_ACTIVE,
    ST_TRAIL
  } busState_t;

  typedef struct packed {
    logic take;      // request latched into pending registers
    logic launch;    // lead phase begins next cycle: drive new address
    logic busOn;     // lead, active or trail in progress
    logic strobeOn;  // active phase in progress
    logic capture;   // final active cycle: sample read data
  } dpCtl_t;
endpackage

// File: rtl/ebm_ctrl.sv
module ebm_ctrl
  import ebm_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             reqWrite,
  input  logic [CNT_W-1:0] rdLead,
  input  logic [CNT_W-1:0] rdActive,
  input  logic [CNT_W-1:0] rdTrail,
  input  logic [CNT_W-1:0] wrLead,
  input  logic [CNT_W-1:0] wrActive,
  input  logic [CNT_W-1:0] wrTrail,
  input  logic             useReady,
  input  logic             doubleTiming,
  input  logic             halfClk,
  input  logic             readyIn,
  output dpCtl_t           ctl,
  output logic             busClk,
  output logic             done,
  output logic             reqReady
);
  localparam int LEN_W = CNT_W + 1;

  function automatic logic [LEN_W-1:0] phaseLen(input logic [CNT_W-1:0] c, input logic dbl);
    logic [LEN_W-1:0] base;
    base = (c == '0) ? LEN_W'(1) : LEN_W'(c);
    return dbl ? (base << 1) : base;
  endfunction

  busState_t        state;
  logic [LEN_W-1:0] cnt;
  logic             isWrite;
  logic             divPhase;
  logic             selWrite;
  logic             cntZero;
  logic             activeEnd;
  logic             needAlign;
  logic [LEN_W-1:0] leadLen, actLen, trailLen;

  assign selWrite  = (state == ST_IDLE) ? reqWrite : isWrite;
  assign cntZero   = (cnt == '0);
  assign activeEnd = (state == ST_ACTIVE) && cntZero && (!useReady || readyIn);
  assign needAlign = halfClk && divPhase;

  always_comb begin
    leadLen  = phaseLen(selWrite ? wrLead   : rdLead,   doubleTiming);
    actLen   = phaseLen(selWrite ? wrActive : rdActive, doubleTiming);
    trailLen = phaseLen(selWrite ? wrTrail  : rdTrail,  doubleTiming);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divPhase <= 1'b0;
    end else begin
      divPhase <= ~divPhase;
    end
  end

  assign busClk = halfClk ? divPhase : clk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      isWrite <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (reqValid) begin
            isWrite <= reqWrite;
            if (needAlign) begin
              state <= ST_ALIGN;
            end else begin
              state <= ST_LEAD;
              cnt   <= leadLen - 1'b1;
            end
          end
        end
        ST_ALIGN: begin
          state <= ST_LEAD;
          cnt   <= leadLen - 1'b1;
        end
        ST_LEAD: begin
          if (cntZero) begin
            state <= ST_ACTIVE;
            cnt   <= actLen - 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_ACTIVE: begin
          if (!cntZero) begin
            cnt <= cnt - 1'b1;
          end else if (activeEnd) begin
            state <= ST_TRAIL;
            cnt   <= trailLen - 1'b1;
          end
        end
        ST_TRAIL: begin
          if (cntZero) begin
            state <= ST_IDLE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl.take     = (state == ST_IDLE) && reqValid;
    ctl.launch   = ((state == ST_IDLE) && reqValid && !needAlign) || (state == ST_ALIGN);
    ctl.busOn    = (state == ST_LEAD) || (state == ST_ACTIVE) || (state == ST_TRAIL);
    ctl.strobeOn = (state == ST_ACTIVE);
    ctl.capture  = activeEnd;
  end

  assign done     = (state == ST_TRAIL) && cntZero;
  assign reqReady = (state == ST_IDLE);
endmodule

// File: rtl/ebm_datapath.sv
module ebm_datapath
  import ebm_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 16,
  parameter int ZONES  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [$clog2(ZONES)-1:0] reqZone,
  input  logic [DATA_W-1:0] dataIn,
  output logic [ZONES-1:0]  csN,
  output logic [ADDR_W-1:0] addrOut,
  output logic              rdN,
  output logic              wrN,
  output logic              rnw,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe,
  output logic [DATA_W-1:0] rdData
);
  localparam int ZONE_W = $clog2(ZONES);

  logic              pendWrite;
  logic [ADDR_W-1:0] pendAddr;
  logic [DATA_W-1:0] pendWdata;
  logic [ZONE_W-1:0] pendZone;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendWrite <= 1'b0;
      pendAddr  <= '0;
      pendWdata <= '0;
      pendZone  <= '0;
    end else if (ctl.take) begin
      pendWrite <= reqWrite;
      pendAddr  <= reqAddr;
      pendWdata <= reqWdata;
      pendZone  <= reqZone;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrOut <= '0;
    end else if (ctl.launch) begin
      addrOut <= ctl.take ? reqAddr : pendAddr;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData <= '0;
    end else if (ctl.capture && !pendWrite) begin
      rdData <= dataIn;
    end
  end

  for (genvar z = 0; z < ZONES; z++) begin : g_cs
    assign csN[z] = !(ctl.busOn && (pendZone == ZONE_W'(z)));
  end

  assign rdN     = !(ctl.strobeOn && !pendWrite);
  assign wrN     = !(ctl.strobeOn && pendWrite);
  assign rnw     = !(ctl.busOn && pendWrite);
  assign dataOut = pendWdata;
  assign dataOe  = ctl.busOn && pendWrite;
endmodule

// File: rtl/ext_bus_master.sv
module ext_bus_master
  import ebm_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 16,
  parameter int ZONES  = 8,
  parameter int CNT_W  = 4,
  localparam int ZONE_W = $clog2(ZONES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              useReady,
  input  logic              doubleTiming,
  input  logic              halfClk,
  input  logic [CNT_W-1:0]  rdLead,
  input  logic [CNT_W-1:0]  rdActive,
  input  logic [CNT_W-1:0]  rdTrail,
  input  logic [CNT_W-1:0]  wrLead,
  input  logic [CNT_W-1:0]  wrActive,
  input  logic [CNT_W-1:0]  wrTrail,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [ZONE_W-1:0] reqZone,
  output logic              reqReady,
  output logic [DATA_W-1:0] rdData,
  output logic              done,
  output logic              busClk,
  output logic [ZONES-1:0]  csN,
  output logic [ADDR_W-1:0] addrOut,
  output logic              rdN,
  output logic              wrN,
  output logic              rnw,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              readyIn
);
  dpCtl_t ctl;

  ebm_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .rdLead(rdLead), .rdActive(rdActive), .rdTrail(rdTrail),
    .wrLead(wrLead), .wrActive(wrActive), .wrTrail(wrTrail),
    .useReady(useReady), .doubleTiming(doubleTiming), .halfClk(halfClk),
    .readyIn(readyIn), .ctl(ctl), .busClk(busClk), .done(done), .reqReady(reqReady)
  );

  ebm_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ZONES(ZONES)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .reqWrite(reqWrite), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .reqZone(reqZone), .dataIn(dataIn), .csN(csN),
    .addrOut(addrOut), .rdN(rdN), .wrN(wrN), .rnw(rnw), .dataOut(dataOut),
    .dataOe(dataOe), .rdData(rdData)
  );
endmodule

// File: rtl/ebm_checker.sv
module ebm_checker #(
  parameter int ADDR_W = 19,
  parameter int ZONES  = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              halfClk,
  input logic              busClk,
  input logic [ZONES-1:0]  csN,
  input logic [ADDR_W-1:0] addrOut,
  input logic              rdN,
  input logic              wrN,
  input logic              rnw,
  input logic              dataOe,
  input logic              done
);
  logic csIdle;
  assign csIdle = &csN;

  AST_SINGLE_ZONE: assert property (@(posedge clk) disable iff (!rstN)
    $countones(~csN) <= 1); // R12
  AST_STROBE_INSIDE_CS: assert property (@(posedge clk) disable iff (!rstN)
    (!rdN || !wrN) |-> !csIdle); // R2
  AST_LEAD_BEFORE_READ: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rdN) |-> $past(!csIdle)); // R2
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    !rdN |-> wrN); // R3
  AST_WRITE_DRIVES: assert property (@(posedge clk) disable iff (!rstN)
    !wrN |-> (dataOe && !rnw)); // R3
  AST_LEAD_ON_RISE: assert property (@(posedge clk) disable iff (!rstN)
    (halfClk && $fell(csIdle)) |-> busClk); // R6
  AST_ADDR_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    csIdle |-> $stable(addrOut)); // R7
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R11
  AST_DONE_LAST_TRAIL: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!csIdle && rdN && wrN)); // R11
endmodule

bind ext_bus_master ebm_checker #(.ADDR_W(ADDR_W), .ZONES(ZONES)) u_chk (
  .clk(clk), .rstN(rstN), .halfClk(halfClk), .busClk(busClk), .csN(csN),
  .addrOut(addrOut), .rdN(rdN), .wrN(wrN), .rnw(rnw), .dataOe(dataOe), .done(done)
);

// File: tb/sim_ext_bus_master.sv
`timescale 1ns/1ps
module sim_ext_bus_master;
  localparam int ADDR_W = 19;
  localparam int DATA_W = 16;
  localparam int ZONES  = 8;
  localparam int CNT_W  = 4;
  localparam int ZONE_W = $clog2(ZONES);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic useReady = 1'b0, doubleTiming = 1'b0, halfClk = 1'b0;
  logic [CNT_W-1:0] rdLead = 1, rdActive = 3, rdTrail = 1;
  logic [CNT_W-1:0] wrLead = 1, wrActive = 1, wrTrail = 1;
  logic reqValid = 1'b0, reqWrite = 1'b0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [DATA_W-1:0] reqWdata = '0;
  logic [ZONE_W-1:0] reqZone = '0;
  logic reqReady, done, busClk, rdN, wrN, rnw, dataOe;
  logic [DATA_W-1:0] rdData, dataOut;
  logic [DATA_W-1:0] dataIn = '0;
  logic readyIn = 1'b0;
  logic [ZONES-1:0] csN;
  logic [ADDR_W-1:0] addrOut;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  ext_bus_master #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ZONES(ZONES), .CNT_W(CNT_W)) u0 (
    .clk(clk), .rstN(rstN), .useReady(useReady), .doubleTiming(doubleTiming),
    .halfClk(halfClk), .rdLead(rdLead), .rdActive(rdActive), .rdTrail(rdTrail),
    .wrLead(wrLead), .wrActive(wrActive), .wrTrail(wrTrail), .reqValid(reqValid),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata), .reqZone(reqZone),
    .reqReady(reqReady), .rdData(rdData), .done(done), .busClk(busClk), .csN(csN),
    .addrOut(addrOut), .rdN(rdN), .wrN(wrN), .rnw(rnw), .dataOut(dataOut),
    .dataOe(dataOe), .dataIn(dataIn), .readyIn(readyIn)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int eff(input int c, input bit dbl);
    int b;
    b = (c == 0) ? 1 : c;
    return dbl ? 2 * b : b;
  endfunction

  // Run one access and check its protocol details; return the phase counts.
  task automatic doAccess(input bit wr, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] wd,
                          input int zone, input int rdyAfter,
                          output int nLead, output int nAct, output int nTrail,
                          output logic [DATA_W-1:0] rdCap);
    logic [ADDR_W-1:0] prevAddr;
    logic [ADDR_W-1:0] leadAddr;
    bit phaseAtReq, leadClk, seenCs, badAlign, badZone, badRnw, badOe, strobe;
    int nAlign, nDone, expAlign;
    nLead = 0; nAct = 0; nTrail = 0; nAlign = 0; nDone = 0; rdCap = '0;
    seenCs = 0; badAlign = 0; badZone = 0; badRnw = 0; badOe = 0;
    leadClk = 0; leadAddr = '0;
    @(negedge clk);
    prevAddr = addrOut;
    reqWrite = wr; reqAddr = a; reqWdata = wd; reqZone = ZONE_W'(zone); reqValid = 1'b1;
    phaseAtReq = busClk;
    @(negedge clk);
    reqValid = 1'b0;
    for (int cyc = 0; cyc < 300; cyc++) begin
      if (&csN) begin
        if (!seenCs) begin
          nAlign++;
          if (addrOut !== prevAddr || !rdN || !wrN) badAlign = 1;
        end
      end else begin
        if (!seenCs) begin
          seenCs = 1; leadClk = busClk; leadAddr = addrOut;
        end
        if (csN !== ~(ZONES'(1) << zone)) badZone = 1;
        if (rnw !== !wr) badRnw = 1;
        if (wr && (!dataOe || dataOut !== wd)) badOe = 1;
        strobe = wr ? wrN : rdN;
        if (!strobe) begin
          nAct++;
          readyIn = (nAct >= rdyAfter);
          dataIn = DATA_W'(16'hA000 + nAct);
        end else if (nAct == 0) begin
          nLead++;
        end else begin
          nTrail++;
        end
        if (done) begin
          nDone++; rdCap = rdData;
        end
      end
      if (done) break;
      @(negedge clk);
    end
    readyIn = 1'b0;
    expAlign = (halfClk && phaseAtReq) ? 1 : 0;
    check(nAlign == expAlign, "R6 alignment cycles", nAlign, expAlign);
    check(!badAlign, "R6 controls inactive while aligning", badAlign, 0);
    if (halfClk) check(leadClk == 1'b1, "R6 lead on bus clock high", leadClk, 1);
    check(leadAddr == a, "R7 address at lead", int'(leadAddr), int'(a));
    check(!badZone, "R12 zone select", badZone, 0);
    check(!badRnw, "R11 direction line", badRnw, 0);
    if (wr) check(!badOe, "R3 write data driven", badOe, 0);
    check(nDone == 1, "R11 one done pulse", nDone, 1);
  endtask

  task automatic setRead(input int l, input int ac, input int t);
    rdLead = CNT_W'(l); rdActive = CNT_W'(ac); rdTrail = CNT_W'(t);
  endtask

  task automatic testReset();
    check(csN == '1, "R1 chip selects idle", int'(csN), 255);
    check(rdN && wrN, "R1 strobes idle", {rdN, wrN}, 3);
    check(rnw == 1'b1, "R1 direction idle", rnw, 1);
    check(dataOe == 1'b0, "R1 data enable", dataOe, 0);
    check(done == 1'b0, "R1 done low", done, 0);
    check(addrOut == '0, "R1 address zero", int'(addrOut), 0);
  endtask

  task automatic testRefRead();
    int l, ac, t; logic [DATA_W-1:0] d;
    setRead(1, 3, 1); useReady = 1; doubleTiming = 0; halfClk = 0;
    doAccess(0, 19'h12345, '0, 2, 3, l, ac, t, d);
    check(l == 1, "R2 read lead", l, 1);
    check(ac == 3, "R2 read active", ac, 3);
    check(t == 1, "R2 read trail", t, 1);
    check(d == 16'hA003, "R10 read capture", d, 16'hA003);
  endtask

  task automatic testReadyWait(input int delay);
    int l, ac, t; logic [DATA_W-1:0] d;
    setRead(1, 3, 1); useReady = 1; doubleTiming = 0; halfClk = 0;
    doAccess(0, 19'h00F00 + ADDR_W'(delay), '0, 1, 3 + delay, l, ac, t, d);
    check(ac == 3 + delay, "R8 ready extension", ac, 3 + delay);
    check(l == 1 && t == 1, "R8 lead and trail unchanged", l * 10 + t, 11);
    check(d == DATA_W'(16'hA000 + 3 + delay), "R10 capture after wait", d, 16'hA000 + 3 + delay);
  endtask

  task automatic testNoReady();
    int l, ac, t; logic [DATA_W-1:0] d;
    setRead(2, 5, 2); useReady = 0; doubleTiming = 0; halfClk = 0;
    doAccess(0, 19'h00ABC, '0, 7, 1000, l, ac, t, d);
    check(ac == 5, "R9 ready ignored", ac, 5);
    check(d == 16'hA005, "R10 capture without ready", d, 16'hA005);
  endtask

  task automatic testWrite();
    int l, ac, t; logic [DATA_W-1:0] d;
    wrLead = 2; wrActive = 4; wrTrail = 3; useReady = 0; doubleTiming = 0; halfClk = 0;
    doAccess(1, 19'h7F001, 16'h5AA5, 5, 1000, l, ac, t, d);
    check(l == 2, "R3 write lead", l, 2);
    check(ac == 4, "R3 write active", ac, 4);
    check(t == 3, "R3 write trail", t, 3);
  endtask

  task automatic testDouble();
    int l, ac, t; logic [DATA_W-1:0] d;
    setRead(1, 3, 1); useReady = 1; doubleTiming = 1; halfClk = 0;
    doAccess(0, 19'h00111, '0, 0, eff(3, 1), l, ac, t, d);
    check(l == eff(1, 1), "R4 doubled lead", l, eff(1, 1));
    check(ac == eff(3, 1), "R4 doubled active", ac, eff(3, 1));
    check(t == eff(1, 1), "R4 doubled trail", t, eff(1, 1));
    setRead(0, 0, 0); doubleTiming = 0;
    doAccess(0, 19'h00222, '0, 3, 1, l, ac, t, d);
    check(l == 1 && ac == 1 && t == 1, "R2 zero counts as one", l * 100 + ac * 10 + t, 111);
  endtask

  task automatic testBusClock();
    bit prev;
    int l, ac, t; logic [DATA_W-1:0] d;
    halfClk = 0;
    @(negedge clk);
    check(busClk == 1'b0, "R5 full-rate low half", busClk, 0);
    @(posedge clk); #1;
    check(busClk == 1'b1, "R5 full-rate high half", busClk, 1);
    halfClk = 1;
    @(negedge clk); prev = busClk;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(busClk == !prev, "R5 half-rate toggle", busClk, !prev);
      prev = busClk;
    end
    setRead(1, 3, 1); useReady = 0; doubleTiming = 0;
    for (int g = 0; g < 3; g++) begin
      repeat (g) @(negedge clk);
      doAccess(0, ADDR_W'(19'h30000 + g), '0, 4, 1000, l, ac, t, d);
      check(l == 1 && ac == 3 && t == 1, "R6 half-rate phase lengths", l * 100 + ac * 10 + t, 131);
    end
    halfClk = 0;
  endtask

  task automatic testHoldAndBackToBack();
    logic [ADDR_W-1:0] last;
    int waitCnt;
    setRead(1, 2, 1); useReady = 0; doubleTiming = 0; halfClk = 0;
    @(negedge clk);
    last = addrOut;
    repeat (3) @(negedge clk);
    check(addrOut == last, "R7 address held while idle", int'(addrOut), int'(last));
    reqWrite = 0; reqAddr = 19'h05555; reqZone = 6; reqValid = 1;
    waitCnt = 0;
    @(negedge clk);
    while (!done && waitCnt < 50) begin @(negedge clk); waitCnt++; end
    @(negedge clk);
    check(csN == '1 && reqReady, "R11 idle cycle after done", {csN == '1, reqReady}, 3);
    @(negedge clk);
    reqValid = 0;
    check(csN != '1, "R11 held request taken after idle", int'(csN), 191);
    waitCnt = 0;
    while (!done && waitCnt < 50) begin @(negedge clk); waitCnt++; end
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    testRefRead();
    testReadyWait(0);
    testReadyWait(2);
    testReadyWait(5);
    testNoReady();
    testWrite();
    testDouble();
    testBusClock();
    testHoldAndBackToBack();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nChecks++; nFails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule